// File: doc/BRIEF.md
# Alternating Octaword DMA Write Collector

This block sits between a slow 16-bit peripheral bus that performs DMA writes and a 32-bit system bus. Incoming words are gathered into two 16-byte buffers, each tied to one naturally aligned 16-byte block of the address space. While one buffer accepts words from the peripheral, the other is written out to memory. The two buffers together can absorb a full 16-word peripheral burst with no stall, even when the system bus has not yet answered.

Each byte in a buffer carries its own valid bit. When a buffer is sealed, it is emptied using the widest aligned system writes that its valid bytes allow. A completely written block goes out as a single 4-longword write. Aligned 8-byte halves that are fully written go out as 2-longword writes. Any other longword that holds valid data is sent as a single-longword write with a byte mask.

A buffer is sealed in four cases: when a word lands in the top word of its block, when the peripheral marks the last word of a burst, when the next word's address falls outside the buffer's block, or when the flush input is raised. The idle output tells the surrounding logic that nothing is held in either buffer.

Top module: `dma_wbuf_pingpong`

## Requirements
- R1: After reset, pw_ready is 1, sb_req is 0 and idle is 1.
- R2: A block whose 16 bytes were all written is drained as one write with sb_size=2 (four longwords), sb_addr equal to the block base, sb_mask=4'hF, and longword k of the block on sb_data[32k+31:32k].
- R3: Two fully valid longwords that start at an 8-byte aligned offset are drained as one write with sb_size=1, sb_mask=4'hF and the lower-addressed longword on sb_data[31:0].
- R4: Any other longword that holds valid bytes is drained with sb_size=0 at its own longword address. sb_mask bit b is set exactly for valid byte b, where byte 0 is the lowest address and sits on sb_data[7:0]. A peripheral word places pw_data[7:0] (pw_be[0]) at its even byte address and pw_data[15:8] (pw_be[1]) at the odd one.
- R5: Accepting a word whose address bits [3:1] equal 7 seals that buffer, and its drain starts without any further input.
- R6: A valid word whose 16-byte block differs from the filling buffer's block seals that buffer, and the word is stored in the other buffer.
- R7: Accepting a word with pw_last=1 seals its buffer.
- R8: With the system bus not answering, 16 consecutive words that cover two aligned blocks are all accepted. The next word sees pw_ready=0 until one buffer has drained.
- R9: A flush pulse seals a partly filled buffer, including in the same cycle that a word is accepted. A flush while both buffers are empty causes no system write and leaves idle at 1.
- R10: idle is 1 exactly when neither buffer holds data that is filling or waiting to drain.
- R11: Buffers drain in the order they were sealed. A request keeps sb_addr, sb_size and sb_mask stable until sb_done is seen, and moves to the next transfer only after sb_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pw_valid | input | 1 | Peripheral word present |
| pw_ready | output | 1 | Word taken on a clock edge where pw_valid is also 1 |
| pw_addr | input | ADDR_W | Byte address of the word (bit 0 is 0) |
| pw_data | input | 16 | Word data |
| pw_be | input | 2 | Byte enables (bit 0 = even byte) |
| pw_last | input | 1 | Final word of the burst |
| flush | input | 1 | Seal any partly filled buffer |
| idle | output | 1 | Both buffers empty |
| sb_req | output | 1 | System write request |
| sb_addr | output | ADDR_W | Longword-aligned byte address of the write |
| sb_size | output | 2 | 0 = one, 1 = two, 2 = four longwords |
| sb_mask | output | 4 | Byte mask for a single-longword write, all ones otherwise |
| sb_data | output | 128 | Write data, first longword in the low lanes |
| sb_done | input | 1 | One-cycle completion of the current request |

## Verification
Two pairs of events can occur in the same clock cycle. The first is a flush arriving together with an accepted word: the bench drives both in one cycle and expects the new byte to be included in the single masked write that follows. The second is a block-leaving word that seals one buffer while the other buffer is still draining or has just been freed: the bench watches the order and contents of the drained writes and requires that the sealed buffer is written out before the word that was redirected to the other buffer. Stalling the system responder shows when the two buffers are both full, which is judged by pw_ready staying low.

// File: rtl/wbuf_pkg.sv
// Shared types for the alternating octaword write collector.
// Assumes a 16-byte block made of eight 16-bit words, or four longwords.
package wbuf_pkg;
    localparam int BLK_BYTES = 16;
    localparam int WORD_PER_BLK = 8;
    localparam int LW_PER_BLK = 4;
    localparam int DATA_W = BLK_BYTES * 8;

    typedef enum logic [1:0] {
        BUF_EMPTY = 2'd0,
        BUF_FILL  = 2'd1,
        BUF_READY = 2'd2
    } buf_state_t;

    typedef enum logic [1:0] {
        XFER_LW = 2'd0,
        XFER_QW = 2'd1,
        XFER_OW = 2'd2
    } xfer_size_t;
endpackage

// File: rtl/wbuf_bank.sv
// One 16-byte collection buffer with per-byte valid bits.
// It is EMPTY, FILL (taking words) or READY (sealed and waiting to drain).
// Assumes no write arrives while READY and that clears come only from the
// drain side when this bank is the selected drain bank.
module wbuf_bank
    import wbuf_pkg::*;
#(
    parameter int BLK_W = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [2:0]           wr_word,
    input  logic [15:0]          wr_data,
    input  logic [1:0]           wr_be,
    input  logic [BLK_W-1:0]     blk_in,
    input  logic                 handoff,
    input  logic                 drain_sel,
    input  logic                 clr_en,
    input  logic [BLK_BYTES-1:0] clr_mask,
    output buf_state_t           state_o,
    output logic [BLK_W-1:0]     blk_o,
    output logic [DATA_W-1:0]    data_o,
    output logic [BLK_BYTES-1:0] valid_o,
    output logic                 drained_o
);
    buf_state_t           state_q;
    logic [BLK_W-1:0]     blk_q;
    logic [DATA_W-1:0]    data_q, data_d;
    logic [BLK_BYTES-1:0] valid_q, valid_d, clr_vec, left_after_clr;

    // Merge the byte writes and drain clears into the next data and valid bits
    always_comb begin
        clr_vec = clr_en ? clr_mask : '0;
        left_after_clr = valid_q & ~clr_vec;
        valid_d = left_after_clr;
        data_d = data_q;
        for (int b = 0; b < BLK_BYTES; b++) begin
            if (wr_en && (wr_word == 3'(b / 2)) && wr_be[b % 2]) begin
                data_d[8*b +: 8] = wr_data[8*(b % 2) +: 8];
                valid_d[b] = 1'b1;
            end
        end
    end

    // The selected sealed bank is finished once no valid byte would remain
    assign drained_o = drain_sel && (state_q == BUF_READY) && (left_after_clr == '0);

    // Register the state, block tag, data and valid bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BUF_EMPTY;
            blk_q   <= '0;
            data_q  <= '0;
            valid_q <= '0;
        end else begin
            data_q  <= data_d;
            valid_q <= valid_d;
            case (state_q)
                BUF_EMPTY: if (wr_en) begin
                    blk_q   <= blk_in;
                    state_q <= handoff ? BUF_READY : BUF_FILL;
                end
                BUF_FILL:  if (handoff) state_q <= BUF_READY;
                BUF_READY: if (drained_o) state_q <= BUF_EMPTY;
                default:   state_q <= BUF_EMPTY;
            endcase
        end
    end

    assign state_o = state_q;
    assign blk_o   = blk_q;
    assign data_o  = data_q;
    assign valid_o = valid_q;

    // R8
    no_write_to_sealed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> state_q != BUF_READY);

    // R11
    sealed_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BUF_READY) && !drained_o |=> state_q == BUF_READY);
endmodule

// File: rtl/wbuf_planner.sv
// Picks the next system write for a sealed buffer from its valid bits.
// The lowest longword with data starts the transfer. A full block becomes
// four longwords, an aligned full pair becomes two, and anything else is a
// single masked longword. Purely combinational.
module wbuf_planner
    import wbuf_pkg::*;
(
    input  logic [BLK_BYTES-1:0] valid,
    output logic                 any_o,
    output logic [1:0]           lw_idx_o,
    output xfer_size_t           size_o,
    output logic [3:0]           mask_o,
    output logic [BLK_BYTES-1:0] clr_mask_o
);
    logic [LW_PER_BLK-1:0] lw_has, lw_full;
    logic                  pair_ok;

    // Summarise each longword and find the first one holding data
    always_comb begin
        for (int i = 0; i < LW_PER_BLK; i++) begin
            lw_has[i]  = |valid[4*i +: 4];
            lw_full[i] = &valid[4*i +: 4];
        end
        any_o = |lw_has;
        lw_idx_o = 2'd0;
        for (int i = LW_PER_BLK - 1; i >= 0; i--) begin
            if (lw_has[i]) lw_idx_o = 2'(i);
        end
    end

    // Choose the widest aligned write and the valid bits it retires
    always_comb begin
        pair_ok = ((lw_idx_o == 2'd0) && lw_full[0] && lw_full[1]) ||
                  ((lw_idx_o == 2'd2) && lw_full[2] && lw_full[3]);
        if (&lw_full) begin
            size_o     = XFER_OW;
            mask_o     = 4'hF;
            clr_mask_o = '1;
        end else if (pair_ok) begin
            size_o     = XFER_QW;
            mask_o     = 4'hF;
            clr_mask_o = 16'h00FF << {lw_idx_o, 2'b00};
        end else begin
            size_o     = XFER_LW;
            mask_o     = valid[{lw_idx_o, 2'b00} +: 4];
            clr_mask_o = 16'h000F << {lw_idx_o, 2'b00};
        end
    end
endmodule

// File: rtl/dma_wbuf_pingpong.sv
// Collects 16-bit DMA write words into two aligned 16-byte buffers that
// alternate between filling and draining to a 32-bit system bus.
// Assumes word-aligned peripheral addresses, ascending bursts, and sb_done
// pulsed for one cycle only while sb_req is high.
module dma_wbuf_pingpong
    import wbuf_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pw_valid,
    output logic              pw_ready,
    input  logic [ADDR_W-1:0] pw_addr,
    input  logic [15:0]       pw_data,
    input  logic [1:0]        pw_be,
    input  logic              pw_last,
    input  logic              flush,
    output logic              idle,
    output logic              sb_req,
    output logic [ADDR_W-1:0] sb_addr,
    output logic [1:0]        sb_size,
    output logic [3:0]        sb_mask,
    output logic [127:0]      sb_data,
    input  logic              sb_done
);
    localparam int BLK_W = ADDR_W - 4;
    localparam int NBUF  = 2;

    buf_state_t           bst    [NBUF];
    logic [BLK_W-1:0]     bblk   [NBUF];
    logic [DATA_W-1:0]    bdata  [NBUF];
    logic [BLK_BYTES-1:0] bvalid [NBUF];
    logic                 bdrained [NBUF];
    logic                 wr_en_b  [NBUF];
    logic                 ho_b     [NBUF];
    logic                 clr_en_b [NBUF];

    logic             fsel, dsel, tgt;
    logic [BLK_W-1:0] blk_in;
    logic             mismatch, acc, end_word, cur_ho, tgt_ho;
    logic [1:0]       lw_idx;
    xfer_size_t       plan_size;
    logic [3:0]       plan_mask;
    logic [BLK_BYTES-1:0] plan_clr;
    logic             plan_any;

    assign blk_in = pw_addr[ADDR_W-1:4];

    // Decide where an incoming word goes and which buffers get sealed
    always_comb begin
        mismatch = (bst[fsel] == BUF_FILL) && (bblk[fsel] != blk_in);
        tgt      = mismatch ? ~fsel : fsel;
        pw_ready = mismatch ? (bst[~fsel] == BUF_EMPTY)
                            : (bst[fsel] == BUF_EMPTY || bst[fsel] == BUF_FILL);
        acc      = pw_valid && pw_ready;
        end_word = (pw_addr[3:1] == 3'd7) || pw_last;
        tgt_ho   = acc && (end_word || flush);
        cur_ho   = (bst[fsel] == BUF_FILL) && ((pw_valid && mismatch) || flush);
        for (int b = 0; b < NBUF; b++) begin
            wr_en_b[b]  = acc && (tgt == 1'(b));
            ho_b[b]     = ((fsel == 1'(b)) && cur_ho) || ((tgt == 1'(b)) && tgt_ho);
            clr_en_b[b] = sb_req && sb_done && (dsel == 1'(b));
        end
    end

    // Advance the fill pointer on acceptance or sealing, the drain pointer on release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsel <= 1'b0;
            dsel <= 1'b0;
        end else begin
            if (tgt_ho)      fsel <= ~tgt;
            else if (acc)    fsel <= tgt;
            else if (cur_ho) fsel <= ~fsel;
            if (bdrained[dsel]) dsel <= ~dsel;
        end
    end

    for (genvar g = 0; g < NBUF; g++) begin : g_bank
        wbuf_bank #(.BLK_W(BLK_W)) i_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (wr_en_b[g]),
            .wr_word   (pw_addr[3:1]),
            .wr_data   (pw_data),
            .wr_be     (pw_be),
            .blk_in    (blk_in),
            .handoff   (ho_b[g]),
            .drain_sel (dsel == 1'(g)),
            .clr_en    (clr_en_b[g]),
            .clr_mask  (plan_clr),
            .state_o   (bst[g]),
            .blk_o     (bblk[g]),
            .data_o    (bdata[g]),
            .valid_o   (bvalid[g]),
            .drained_o (bdrained[g])
        );
    end

    wbuf_planner i_planner (
        .valid      (bvalid[dsel]),
        .any_o      (plan_any),
        .lw_idx_o   (lw_idx),
        .size_o     (plan_size),
        .mask_o     (plan_mask),
        .clr_mask_o (plan_clr)
    );

    // Present the planned transfer of the oldest sealed buffer
    always_comb begin
        sb_req  = (bst[dsel] == BUF_READY) && plan_any;
        sb_addr = {bblk[dsel], lw_idx, 2'b00};
        sb_size = plan_size;
        sb_mask = plan_mask;
        sb_data = bdata[dsel] >> {lw_idx, 5'b00000};
        idle    = (bst[0] == BUF_EMPTY) && (bst[1] == BUF_EMPTY);
    end

    // R10
    idle_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> !sb_req);

    // R2
    ow_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sb_req && (sb_size == 2'd2) |-> (sb_addr[3:0] == 4'h0) && (sb_mask == 4'hF));

    // R3
    qw_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sb_req && (sb_size == 2'd1) |-> (sb_addr[2:0] == 3'h0) && (sb_mask == 4'hF));

    // R4
    lw_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sb_req && (sb_size == 2'd0) |-> sb_mask != 4'h0);

    // R11
    req_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sb_req && !sb_done |=> sb_req && $stable(sb_addr) && $stable(sb_size) && $stable(sb_mask));

    // R11
    done_with_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sb_done |-> sb_req);

    // R4
    word_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pw_valid |-> !pw_addr[0]);
endmodule

// File: tb/test_dma_wbuf_pingpong.sv
module test_dma_wbuf_pingpong;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pw_valid = 1'b0;
    logic          pw_ready;
    logic [AW-1:0] pw_addr = '0;
    logic [15:0]   pw_data = '0;
    logic [1:0]    pw_be = '0;
    logic          pw_last = 1'b0;
    logic          flush = 1'b0;
    logic          idle;
    logic          sb_req;
    logic [AW-1:0] sb_addr;
    logic [1:0]    sb_size;
    logic [3:0]    sb_mask;
    logic [127:0]  sb_data;
    logic          sb_done = 1'b0;
    logic          sb_stall = 1'b0;

    int checks = 0;
    int fails = 0;
    int nlog = 0;
    logic [AW-1:0] lg_addr [64];
    logic [1:0]    lg_size [64];
    logic [3:0]    lg_mask [64];
    logic [127:0]  lg_data [64];

    dma_wbuf_pingpong #(.ADDR_W(AW)) i_dma_wbuf_pingpong (
        .clk(clk), .rst_n(rst_n), .pw_valid(pw_valid), .pw_ready(pw_ready),
        .pw_addr(pw_addr), .pw_data(pw_data), .pw_be(pw_be), .pw_last(pw_last),
        .flush(flush), .idle(idle), .sb_req(sb_req), .sb_addr(sb_addr),
        .sb_size(sb_size), .sb_mask(sb_mask), .sb_data(sb_data), .sb_done(sb_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // System bus responder: logs each request and completes it one cycle later
    initial begin
        forever begin
            @(negedge clk);
            if (sb_done) sb_done = 1'b0;
            else if (rst_n && sb_req && !sb_stall) begin
                if (nlog < 64) begin
                    lg_addr[nlog] = sb_addr;
                    lg_size[nlog] = sb_size;
                    lg_mask[nlog] = sb_mask;
                    lg_data[nlog] = sb_data;
                end
                nlog++;
                sb_done = 1'b1;
            end
        end
    end

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: run did not complete (actual hung, expected finish)");
        finish_run();
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Compare one logged transfer; only the lanes the size covers are compared
    task automatic chk_entry(input int idx, input string req, input logic [AW-1:0] a,
                             input logic [1:0] sz, input logic [3:0] m,
                             input logic [127:0] d, input logic [127:0] dmask);
        logic [127:0] act, exp;
        act = {lg_addr[idx], lg_size[idx], lg_mask[idx]};
        exp = {a, sz, m};
        chk(idx < nlog && act == exp, req, $sformatf("entry %0d addr/size/mask", idx), act, exp);
        chk(idx < nlog && (lg_data[idx] & dmask) == (d & dmask), req,
            $sformatf("entry %0d data", idx), lg_data[idx] & dmask, d & dmask);
    endtask

    task automatic send_word(input logic [AW-1:0] a, input logic [15:0] d,
                             input logic [1:0] be, input logic last, input logic fl);
        @(negedge clk);
        pw_valid = 1'b1; pw_addr = a; pw_data = d; pw_be = be; pw_last = last; flush = fl;
        #1;
        while (!pw_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        pw_valid = 1'b0; pw_last = 1'b0; flush = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            #2;
            if (idle) break;
        end
    endtask

    task automatic t_reset();
        #1;
        chk(pw_ready == 1'b1, "R1", "pw_ready after reset", 128'(pw_ready), 128'(1));
        chk(sb_req == 1'b0, "R1", "sb_req after reset", 128'(sb_req), 128'(0));
        chk(idle == 1'b1, "R1", "idle after reset", 128'(idle), 128'(1));
    endtask

    // R2 and R5: a full block with no last flag is sealed by its top word
    task automatic t_full_block();
        int base;
        logic [127:0] exp;
        base = nlog;
        for (int k = 0; k < 8; k++) begin
            send_word(24'h000100 + 24'(2 * k), 16'h1100 + 16'(k), 2'b11, 1'b0, 1'b0);
            exp[16*k +: 16] = 16'h1100 + 16'(k);
        end
        wait_idle();
        chk(nlog - base == 1, "R5", "writes for full block", 128'(nlog - base), 128'(1));
        chk_entry(base, "R2", 24'h000100, 2'd2, 4'hF, exp, '1);
    endtask

    // R3 and R7: odd longword alone, then an aligned pair, sealed by last
    task automatic t_pair();
        int base;
        base = nlog;
        for (int k = 2; k < 8; k++)
            send_word(24'h000200 + 24'(2 * k), 16'h2200 + 16'(k), 2'b11, k == 7, 1'b0);
        wait_idle();
        chk(nlog - base == 2, "R3", "writes for split block", 128'(nlog - base), 128'(2));
        chk_entry(base, "R4", 24'h000204, 2'd0, 4'hF, {96'h0, 16'h2203, 16'h2202}, 128'hFFFFFFFF);
        chk_entry(base + 1, "R3", 24'h000208, 2'd1, 4'hF,
                  {64'h0, 16'h2207, 16'h2206, 16'h2205, 16'h2204}, {64'h0, 64'hFFFFFFFFFFFFFFFF});
    endtask

    // R4 and R7: a single upper byte, sealed early by last
    task automatic t_partial();
        int base;
        base = nlog;
        send_word(24'h000302, 16'hBEEF, 2'b10, 1'b1, 1'b0);
        wait_idle();
        chk(nlog - base == 1, "R7", "writes after last", 128'(nlog - base), 128'(1));
        chk_entry(base, "R4", 24'h000300, 2'd0, 4'b1000, {96'h0, 8'hBE, 24'h0}, 128'hFF000000);
    endtask

    // R6 and R11: leaving the block seals the first buffer, drains stay ordered
    task automatic t_leave_block();
        int base;
        base = nlog;
        send_word(24'h000400, 16'h4400, 2'b11, 1'b0, 1'b0);
        send_word(24'h000402, 16'h4402, 2'b11, 1'b0, 1'b0);
        send_word(24'h000410, 16'h4410, 2'b01, 1'b1, 1'b0);
        wait_idle();
        chk(nlog - base == 2, "R6", "writes after block change", 128'(nlog - base), 128'(2));
        chk_entry(base, "R11", 24'h000400, 2'd0, 4'hF, {96'h0, 16'h4402, 16'h4400}, 128'hFFFFFFFF);
        chk_entry(base + 1, "R6", 24'h000410, 2'd0, 4'b0001, {120'h0, 8'h10}, 128'hFF);
    endtask

    // R8, R10, R11: both buffers filled under a stalled system bus
    task automatic t_double_full();
        int base;
        bit stalled;
        logic [127:0] e0, e1;
        base = nlog;
        sb_stall = 1'b1;
        for (int k = 0; k < 16; k++) begin
            send_word(24'h000600 + 24'(2 * k), 16'h6600 + 16'(k), 2'b11, k == 15, 1'b0);
            if (k < 8) e0[16*k +: 16] = 16'h6600 + 16'(k);
            else       e1[16*(k-8) +: 16] = 16'h6600 + 16'(k);
        end
        @(negedge clk);
        pw_valid = 1'b1; pw_addr = 24'h000620; pw_data = 16'h6620; pw_be = 2'b11;
        stalled = 1'b1;
        for (int i = 0; i < 5; i++) begin
            #1;
            if (pw_ready) stalled = 1'b0;
            @(negedge clk);
        end
        chk(stalled, "R8", "pw_ready low with both buffers sealed", 128'(!stalled), 128'(0));
        chk(idle == 1'b0, "R10", "idle while data held", 128'(idle), 128'(0));
        pw_valid = 1'b0;
        chk(nlog == base, "R8", "16 words taken with no drain", 128'(nlog - base), 128'(0));
        sb_stall = 1'b0;
        wait_idle();
        chk(idle == 1'b1, "R10", "idle after both drained", 128'(idle), 128'(1));
        chk_entry(base, "R11", 24'h000600, 2'd2, 4'hF, e0, '1);
        chk_entry(base + 1, "R11", 24'h000610, 2'd2, 4'hF, e1, '1);
    endtask

    // R9: flush seals a partial buffer; flush with nothing held does nothing
    task automatic t_flush();
        int base;
        bit quiet;
        base = nlog;
        send_word(24'h000700, 16'h7700, 2'b11, 1'b0, 1'b0);
        repeat (4) @(negedge clk);
        #1;
        chk(nlog == base && !sb_req, "R9", "partial buffer held before flush", 128'(sb_req), 128'(0));
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        wait_idle();
        chk(nlog - base == 1, "R9", "writes after flush", 128'(nlog - base), 128'(1));
        chk_entry(base, "R9", 24'h000700, 2'd0, 4'b0011, {112'h0, 16'h7700}, 128'hFFFF);
        base = nlog;
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        quiet = 1'b1;
        for (int i = 0; i < 4; i++) begin
            #1;
            if (sb_req || !idle) quiet = 1'b0;
            @(negedge clk);
        end
        chk(quiet && nlog == base, "R9", "flush while empty", 128'(nlog - base), 128'(0));
    endtask

    // R9: flush in the same cycle a word is taken includes that word
    task automatic t_flush_with_word();
        int base;
        base = nlog;
        send_word(24'h000806, 16'h8806, 2'b11, 1'b0, 1'b1);
        wait_idle();
        chk(nlog - base == 1, "R9", "writes after flush with word", 128'(nlog - base), 128'(1));
        chk_entry(base, "R9", 24'h000804, 2'd0, 4'b1100, {96'h0, 16'h8806, 16'h0}, 128'hFFFF0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_full_block();
        t_pair();
        t_partial();
        t_leave_block();
        t_double_full();
        t_flush();
        t_flush_with_word();
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule